// File: doc/BRIEF.md
# Memory Stuck-at-Zero Self-Test Controller

This block wraps a single-port synchronous RAM with a self-test engine. In functional mode, the RAM port belongs to the user. Each clock can carry one write, or one read whose word returns on the following clock. No handshake is involved, so the port never pushes back and never stalls.

When test mode is high and the start input rises, an internal sequencer takes the RAM port. It first writes an all-ones word into every location, in ascending order. It then reads every location back in the same order. Each returned word is reduced with a bitwise AND, so any cell that cannot hold a one is caught. The engine then raises a done flag and presents a status bit: 0 means every word read back as all ones, and 1 means at least one word did not.

A fault-injection input pair lets a bench force one chosen location to store the inverse of what is written to it. This models a cell that reads back as zero.

Top module: `mbist_wrap`

## Requirements
- R1: With test_mode low, a write (usr_we high) stores usr_wdata at usr_addr on that clock edge, and a read places the word at usr_addr on usr_rdata one clock after the address is sampled.
- R2: A rising edge of start, sampled while test_mode is high, starts a run. The run writes the all-ones word to every address from 0 up to DEPTH-1, then reads every address from 0 up to DEPTH-1, so afterwards every healthy location holds all ones.
- R3: Let k be the clock edge that samples start rising. done is low up to and including edge k+2*DEPTH and goes high after edge k+2*DEPTH+1.
- R4: With done high, status is 0 if every word read back has all bits set, and 1 if any word read back has a zero bit. This includes the word at the last address.
- R5: A failure at any location keeps status at 1 until the run ends, even when every later location is good.
- R6: Once done is high, done and status hold their values until the next rising edge of start. Holding start high does not begin a new run, and a new rising edge clears done one clock later.
- R7: While test_mode is low, the RAM is driven only by the user port, and start is ignored. Raising test_mode while start is already high does not begin a run.
- R8: A synchronous reset forces done and status to 0 and returns the engine to idle.
- R9: A user write presented in a clock whose edge samples test_mode high has no effect on the RAM.
- R10: Dropping test_mode during a run aborts it. On the next clock, done and status are 0, and no run resumes until a fresh rising edge of start.
- R11: While flt_en is high, any write to address flt_addr stores the bitwise inverse of the written word. Writes to other addresses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 gives the RAM port to the self-test engine |
| start | input | 1 | Its rising edge begins a run while test_mode is high |
| usr_we | input | 1 | User write enable |
| usr_addr | input | AW | User address |
| usr_wdata | input | WIDTH | User write data |
| usr_rdata | output | WIDTH | Read data, one clock after the address |
| flt_en | input | 1 | Enables fault injection |
| flt_addr | input | AW | Location that stores inverted data |
| done | output | 1 | Run finished; status is valid |
| status | output | 1 | 0 means pass, 1 means fail |

## Verification
The bench builds the block with DEPTH=64 and WIDTH=16. With these values a full run takes 129 clocks, so the exact done cycle, the wrap from the last write address into the read pass, and the final-word comparison can all be reached in a short run. The small depth also lets the bench place an injected fault at address 0, to show that status stays set across the remaining good words. It places another at address 63, to show that the word compared in the last cycle before done still counts.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_COMPARE,
    ST_DONE
  } mbist_state_e;
endpackage

// File: rtl/mbist_ram.sv
module mbist_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             flt_en,
  input  logic [AW-1:0]    flt_addr
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             flt_hit;

  // fault hook: selected cell stores inverted data (models cells reading zero)
  assign flt_hit = flt_en && (addr == flt_addr);

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= flt_hit ? ~wdata : wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mbist_port_mux.sv
module mbist_port_mux #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             sel_test,
  input  logic             usr_we,
  input  logic [AW-1:0]    usr_addr,
  input  logic [WIDTH-1:0] usr_wdata,
  input  logic             gen_we,
  input  logic [AW-1:0]    gen_addr,
  input  logic [WIDTH-1:0] gen_wdata,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [WIDTH-1:0] ram_wdata
);
  always_comb begin
    if (sel_test) begin
      ram_we    = gen_we;
      ram_addr  = gen_addr;
      ram_wdata = gen_wdata;
    end else begin
      ram_we    = usr_we;
      ram_addr  = usr_addr;
      ram_wdata = usr_wdata;
    end
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode,
  input  logic             start,
  input  logic [WIDTH-1:0] rdata,
  output logic             gen_we,
  output logic [AW-1:0]    gen_addr,
  output logic [WIDTH-1:0] gen_wdata,
  output logic             done,
  output logic             fail
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  mbist_state_e st;
  logic [AW-1:0] cnt;
  logic          start_q;
  logic          chk_vld;
  logic          fail_q;
  logic          go;
  logic          word_bad;

  assign go       = test_mode && start && !start_q && (st == ST_IDLE || st == ST_DONE);
  assign word_bad = chk_vld && !(&rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      start_q <= 1'b0;
      chk_vld <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      start_q <= start;
      chk_vld <= test_mode && (st == ST_READ);
      if (!test_mode) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        fail_q <= 1'b0;
      end else begin
        if ((st == ST_READ || st == ST_COMPARE) && word_bad) fail_q <= 1'b1;
        case (st)
          ST_IDLE, ST_DONE: begin
            if (go) begin
              st     <= ST_WRITE;
              cnt    <= '0;
              fail_q <= 1'b0;
            end
          end
          ST_WRITE: begin
            if (cnt == LAST) begin
              st  <= ST_READ;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (cnt == LAST) begin
              st  <= ST_COMPARE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_COMPARE: st <= ST_DONE;
          default:    st <= ST_IDLE;
        endcase
      end
    end
  end

  assign gen_we    = (st == ST_WRITE);
  assign gen_addr  = cnt;
  assign gen_wdata = '1;
  assign done      = (st == ST_DONE);
  assign fail      = fail_q;

  AST_WRITE_WRAPS_TO_READ: assert property (@(posedge clk) disable iff (rst)
    (test_mode && st == ST_WRITE && cnt == LAST) |=> (st == ST_READ && cnt == '0)); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (test_mode && fail_q && !go) |=> fail_q); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (test_mode && st == ST_DONE && !go) |=> (st == ST_DONE)); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> (!gen_we && !done && !fail_q)); // R10
  AST_NO_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !gen_we); // R6
endmodule

// File: rtl/mbist_wrap.sv
module mbist_wrap #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode,
  input  logic             start,
  input  logic             usr_we,
  input  logic [AW-1:0]    usr_addr,
  input  logic [WIDTH-1:0] usr_wdata,
  output logic [WIDTH-1:0] usr_rdata,
  input  logic             flt_en,
  input  logic [AW-1:0]    flt_addr,
  output logic             done,
  output logic             status
);
  logic             gen_we;
  logic [AW-1:0]    gen_addr;
  logic [WIDTH-1:0] gen_wdata;
  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [WIDTH-1:0] ram_wdata;
  logic [WIDTH-1:0] ram_rdata;

  mbist_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .rdata(ram_rdata), .gen_we(gen_we), .gen_addr(gen_addr),
    .gen_wdata(gen_wdata), .done(done), .fail(status)
  );

  mbist_port_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mux (
    .sel_test(test_mode), .usr_we(usr_we), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .gen_we(gen_we), .gen_addr(gen_addr),
    .gen_wdata(gen_wdata), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata)
  );

  mbist_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
    .rdata(ram_rdata), .flt_en(flt_en), .flt_addr(flt_addr)
  );

  assign usr_rdata = ram_rdata;

  AST_ENGINE_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !gen_we); // R7
  AST_STATUS_LOW_ON_RESET: assert property (@(posedge clk)
    rst |=> (!done && !status)); // R8
endmodule

// File: tb/mbist_wrap_tb.sv
module mbist_wrap_tb;
  localparam int DEPTH = 64;
  localparam int WIDTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [WIDTH-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst, test_mode, start, usr_we, flt_en, done, status;
  logic [AW-1:0] usr_addr, flt_addr;
  logic [WIDTH-1:0] usr_wdata, usr_rdata;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbist_wrap #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .usr_we(usr_we), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_rdata(usr_rdata), .flt_en(flt_en), .flt_addr(flt_addr),
    .done(done), .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk); usr_we = 1'b1; usr_addr = a; usr_wdata = d;
    @(negedge clk); usr_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [WIDTH-1:0] d);
    @(negedge clk); usr_we = 1'b0; usr_addr = a;
    @(negedge clk); d = usr_rdata;
  endtask

  // leaves start high, ends at a negedge with done high
  task automatic run_bist(input bit exp_st, input string tag);
    @(negedge clk); start = 1'b1;
    repeat (2*DEPTH+1) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, {tag, " R3 done early"}, done, 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, {tag, " R3 done on time"}, done, 1);
    check(status == exp_st, {tag, " R4 status"}, status, exp_st);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 1'b0 && status == 1'b0, "R8 reset state", {done, status}, 0);
  endtask

  task automatic t_normal();
    logic [WIDTH-1:0] d;
    wr(3, 16'hA5C3); wr(DEPTH-1, 16'h0F0F);
    rd(3, d);       check(d == 16'hA5C3, "R1 read addr 3", d, 16'hA5C3);
    rd(DEPTH-1, d); check(d == 16'h0F0F, "R1 read last addr", d, 16'h0F0F);
  endtask

  task automatic t_fault_hook();
    logic [WIDTH-1:0] d;
    flt_en = 1'b1; flt_addr = 7;
    wr(7, 16'h1234); wr(8, 16'h5678);
    flt_en = 1'b0;
    rd(7, d); check(d == ~16'h1234, "R11 inverted store", d, ~16'h1234);
    rd(8, d); check(d == 16'h5678, "R11 neighbour intact", d, 16'h5678);
  endtask

  task automatic t_mode_blocks_user();
    logic [WIDTH-1:0] d;
    wr(5, 16'h1111);
    @(negedge clk); test_mode = 1'b1; usr_we = 1'b1; usr_addr = 5; usr_wdata = 16'hBEEF;
    @(negedge clk); test_mode = 1'b0; usr_we = 1'b0;
    rd(5, d); check(d == 16'h1111, "R9 user write ignored in test mode", d, 16'h1111);
  endtask

  task automatic t_clean_run();
    logic [WIDTH-1:0] d;
    @(negedge clk); test_mode = 1'b1; start = 1'b0;
    run_bist(1'b0, "clean");
    @(negedge clk); test_mode = 1'b0; start = 1'b0;
    rd(0, d);       check(d == ONES, "R2 addr 0 filled", d, ONES);
    rd(5, d);       check(d == ONES, "R2 addr 5 filled", d, ONES);
    rd(DEPTH-1, d); check(d == ONES, "R2 last addr filled", d, ONES);
  endtask

  task automatic t_done_hold();
    @(negedge clk); test_mode = 1'b1; start = 1'b0;
    run_bist(1'b0, "hold");
    repeat (10) @(negedge clk);
    check(done == 1'b1 && status == 1'b0, "R6 done held with start high", {done, status}, 2);
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R6 new edge restarts", done, 0);
    @(negedge clk); start = 1'b0; test_mode = 1'b0;
  endtask

  task automatic t_fault_run(input logic [AW-1:0] a, input string tag);
    @(negedge clk); test_mode = 1'b1; start = 1'b0; flt_en = 1'b1; flt_addr = a;
    run_bist(1'b1, tag);
    repeat (5) @(negedge clk);
    check(status == 1'b1 && done == 1'b1, {tag, " R5 fail stays"}, {done, status}, 3);
    flt_en = 1'b0;
  endtask

  task automatic t_sync_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(done == 1'b0 && status == 1'b0, "R8 sync reset clears", {done, status}, 0);
    start = 1'b0; test_mode = 1'b0;
  endtask

  task automatic t_start_ignored();
    @(negedge clk); test_mode = 1'b0; start = 1'b1;
    repeat (3) @(negedge clk);
    test_mode = 1'b1;
    repeat (2*DEPTH+4) @(negedge clk);
    check(done == 1'b0, "R7 no run without edge in test mode", done, 0);
    start = 1'b0; test_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    @(negedge clk); test_mode = 1'b1; flt_en = 1'b1; flt_addr = 0;
    @(negedge clk); start = 1'b1;
    repeat (DEPTH+10) @(negedge clk);
    test_mode = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && status == 1'b0, "R10 abort clears", {done, status}, 0);
    test_mode = 1'b1;
    repeat (2*DEPTH+4) @(negedge clk);
    check(done == 1'b0, "R10 no resume after abort", done, 0);
    start = 1'b0; test_mode = 1'b0; flt_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; test_mode = 1'b0; start = 1'b0; usr_we = 1'b0;
    usr_addr = '0; usr_wdata = '0; flt_en = 1'b0; flt_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_fault_hook();
    t_mode_blocks_user();
    t_clean_run();
    t_done_hold();
    t_fault_run(0, "fault@0");
    t_fault_run(AW'(DEPTH-1), "fault@last");
    t_sync_reset();
    t_start_ignored();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule